// File: doc/BRIEF.md
# Power-of-Two Clock Output Divider

This block produces one clock-output pin from a choice of on-chip clocks. A two-bit source code picks the external crystal clock, the system bus clock or the internal RC oscillator. A module gate then passes or blocks the chosen clock, and the result drives a chain of divide-by-two stages. A select value N picks one tap of that chain, so the pin toggles at the divider clock frequency divided by 2^(N+1). A bypass control sends the undivided divider clock to the pin.

The enable passes through a two-flop synchronizer into the divider clock domain. Setting the enable restarts the chain from wherever it stopped. Clearing it lets the chain run on until the selected tap is low, so the last high phase is never cut short. The pin then stays low. The reset is synchronous and active high, and it is sampled on the divider clock. A source must therefore be running while reset is held.

Top module: `clkout_div`

## Requirements
- R1: While `rst` is high at a rising edge of the divider clock, every divider stage and the output register clear, so `clk_out` is low. It stays low after reset until the enable is set.
- R2: With `bypass` = 0 and the divider enabled, `clk_out` has a period of exactly 2^(N+1) divider clock periods, where N = `div_sel`. Its high and low phases are each half of that period.
- R3: `div_sel` is sampled on the divider clock. After a change of N, the interval between the second and third rising edges of `clk_out` already equals the new period.
- R4: `div_en` reaches the divider through two flops clocked by the divider clock. While the synchronized enable is high, the chain advances by one count on every divider clock edge. Setting the enable after a stop resumes from the held count, and the first high phase is full width.
- R5: After `div_en` is cleared, any high phase under way completes at its full width of 2^N divider clocks. `clk_out` is then low within one output period plus four divider clocks, and it stays low while the enable remains clear.
- R6: `src_sel` = 2'b00 selects `clk_xtal`, 2'b10 selects `clk_bus` and 2'b11 selects `clk_irc` as the divider clock.
- R7: `src_sel` = 2'b01 is reserved. It forces the divider clock low, so `clk_out` makes no transitions.
- R8: With `clk_gate_en` = 0 the divider clock is held low, and `clk_out` makes no transitions even with `bypass` = 1.
- R9: With `bypass` = 1, `clk_out` carries the divider clock itself, with the period of the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled on the divider clock |
| clk_xtal | input | 1 | External crystal clock, source code 2'b00 |
| clk_bus | input | 1 | System bus clock, source code 2'b10 |
| clk_irc | input | 1 | Internal RC oscillator clock, source code 2'b11 |
| src_sel | input | 2 | Divider clock source code |
| clk_gate_en | input | 1 | Module clock gate, 1 passes the selected source |
| div_en | input | 1 | Divider enable, asynchronous to the divider clock |
| div_sel | input | SEL_W | Tap select N, output = divider clock / 2^(N+1) |
| bypass | input | 1 | 1 routes the undivided divider clock to the pin |
| clk_out | output | 1 | Clock output |

## Verification
The bench builds the block with STAGES = 8, which makes SEL_W = 3. At that size the slowest tap lasts 256 source cycles, so every tap, including the last one, has its period and duty measured several times within the run. The three sources get periods of 8, 16 and 24 ns, so a wrong source code shows up as a wrong period. Disable is exercised once during a high phase and once during a low phase, and a pulse-width monitor watches the high phases.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    localparam int SRC_W = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_XTAL = 2'b00,
        SRC_RSVD = 2'b01,
        SRC_BUS  = 2'b10,
        SRC_IRC  = 2'b11
    } src_e;

    // chain advances while enabled, or while the selected tap is still high
    function automatic logic chain_advance(input logic en_s, input logic tap);
        return en_s | tap;
    endfunction

endpackage

// File: rtl/clkout_src_sel.sv
`timescale 1ns/1ps
module clkout_src_sel
    import clkdiv_pkg::*;
(
    input  logic             clk_xtal,
    input  logic             clk_bus,
    input  logic             clk_irc,
    input  logic [SRC_W-1:0] src_sel,
    input  logic             gate_en,
    output logic             div_clk
);
    logic picked;

    always_comb begin
        case (src_e'(src_sel))
            SRC_XTAL: picked = clk_xtal;
            SRC_BUS:  picked = clk_bus;
            SRC_IRC:  picked = clk_irc;
            default:  picked = 1'b0;
        endcase
    end

    assign div_clk = picked & gate_en;

endmodule

// File: rtl/clkout_sync.sv
`timescale 1ns/1ps
module clkout_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/clkout_chain.sv
`timescale 1ns/1ps
module clkout_chain
    import clkdiv_pkg::*;
#(
    parameter int STAGES = 16,
    parameter int SEL_W  = $clog2(STAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_s,
    input  logic [SEL_W-1:0] sel,
    output logic             tap_out
);
    typedef logic [STAGES-1:0] cnt_t;

    cnt_t             cnt;
    cnt_t             cnt_nx;
    logic [SEL_W-1:0] sel_q;
    logic             out_q;
    logic             adv;

    always_comb begin
        adv    = chain_advance(en_s, cnt[sel_q]);
        cnt_nx = adv ? cnt + cnt_t'(1) : cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sel_q <= '0;
            out_q <= 1'b0;
        end else begin
            cnt   <= cnt_nx;
            sel_q <= sel;
            out_q <= cnt_nx[sel_q];
        end
    end

    assign tap_out = out_q;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0 && !out_q)); // R1
    AST_RUN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        en_s |=> (cnt == $past(cnt) + cnt_t'(1))); // R4
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!en_s && !cnt[sel_q]) |=> (cnt == $past(cnt))); // R5
    AST_HELD_LOW: assert property (@(posedge clk) disable iff (rst)
        (!en_s && !out_q && $stable(sel_q)) |=> !out_q); // R5

endmodule

// File: rtl/clkout_div.sv
`timescale 1ns/1ps
module clkout_div
    import clkdiv_pkg::*;
#(
    parameter int STAGES = 16,
    parameter int SEL_W  = $clog2(STAGES)
) (
    input  logic             rst,
    input  logic             clk_xtal,
    input  logic             clk_bus,
    input  logic             clk_irc,
    input  logic [SRC_W-1:0] src_sel,
    input  logic             clk_gate_en,
    input  logic             div_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             bypass,
    output logic             clk_out
);
    logic div_clk;
    logic en_s;
    logic tap;

    clkout_src_sel u_src (
        .clk_xtal (clk_xtal),
        .clk_bus  (clk_bus),
        .clk_irc  (clk_irc),
        .src_sel  (src_sel),
        .gate_en  (clk_gate_en),
        .div_clk  (div_clk)
    );

    clkout_sync u_sync (
        .clk (div_clk),
        .rst (rst),
        .d   (div_en),
        .q   (en_s)
    );

    clkout_chain #(.STAGES(STAGES), .SEL_W(SEL_W)) u_chain (
        .clk     (div_clk),
        .rst     (rst),
        .en_s    (en_s),
        .sel     (div_sel),
        .tap_out (tap)
    );

    assign clk_out = bypass ? div_clk : tap;

endmodule

// File: tb/clkout_div_test.sv
`timescale 1ns/1ps
module clkout_div_test;
    localparam int STAGES = 8;
    localparam int SEL_W  = $clog2(STAGES);

    logic clk = 0, clk_bus = 0, clk_irc = 0;
    logic rst = 1, gate = 1, en = 0, byp = 0;
    logic [1:0] src = 2'b00;
    logic [SEL_W-1:0] sel = '0;
    logic clk_out;

    always #4  clk     = ~clk;
    always #8  clk_bus = ~clk_bus;
    always #12 clk_irc = ~clk_irc;

    clkout_div #(.STAGES(STAGES)) uut (
        .rst(rst), .clk_xtal(clk), .clk_bus(clk_bus), .clk_irc(clk_irc),
        .src_sel(src), .clk_gate_en(gate), .div_en(en), .div_sel(sel),
        .bypass(byp), .clk_out(clk_out)
    );

    int n_chk = 0, n_bad = 0;
    longint rise_t = 0, edges = 0, mon_half = 0;
    bit mon_on = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint src_per(input logic [1:0] s);
        case (s)
            2'b00: return 8;
            2'b10: return 16;
            2'b11: return 24;
            default: return 0;
        endcase
    endfunction

    function automatic longint exp_per(input logic [1:0] s, input int n);
        return src_per(s) << (n + 1);
    endfunction

    always @(clk_out) edges++;
    always @(posedge clk_out) rise_t = $time;
    always @(negedge clk_out)
        if (mon_on) check(($time - rise_t) == mon_half, "R5", "high width",
                          $time - rise_t, mon_half);

    task automatic measure(output longint per);
        longint t0;
        @(posedge clk_out); t0 = $time;
        @(posedge clk_out); per = $time - t0;
    endtask

    task automatic cfg(input logic [1:0] s, input int n);
        @(negedge clk);
        src = s;
        sel = SEL_W'(n);
    endtask

    task automatic quiet(input string req, input int cycles);
        longint e0;
        repeat (5) @(negedge clk);
        e0 = edges;
        repeat (cycles) @(negedge clk);
        check(edges == e0, req, "edges while quiet", edges - e0, 0);
    endtask

    initial begin
        #1600000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint per, t0, e0;
        logic [1:0] srcs [3] = '{2'b00, 2'b10, 2'b11};
        void'($urandom(32'h5EED));

        repeat (10) @(negedge clk);
        check(clk_out == 0, "R1", "out in reset", clk_out, 0);
        rst = 0;
        repeat (20) @(negedge clk);
        check(clk_out == 0, "R1", "out idle after reset", clk_out, 0);

        en = 1;
        for (int n = 0; n < STAGES; n++) begin
            cfg(2'b00, n);
            repeat (1) @(posedge clk_out);
            measure(per);
            check(per == exp_per(2'b00, n), "R2", "period", per, exp_per(2'b00, n));
            @(posedge clk_out); t0 = $time;
            @(negedge clk_out);
            check(($time - t0) == exp_per(2'b00, n) / 2, "R2", "high phase",
                  $time - t0, exp_per(2'b00, n) / 2);
        end

        // R3: large jumps of the select
        cfg(2'b00, 0);
        @(posedge clk_out);
        measure(per);
        cfg(2'b00, STAGES - 1);
        @(posedge clk_out);
        measure(per);
        check(per == exp_per(2'b00, STAGES - 1), "R3", "period after up", per,
              exp_per(2'b00, STAGES - 1));
        cfg(2'b00, 1);
        @(posedge clk_out);
        measure(per);
        check(per == exp_per(2'b00, 1), "R3", "period after down", per, exp_per(2'b00, 1));

        // R6: random source and tap
        for (int i = 0; i < 12; i++) begin
            logic [1:0] s;
            int n;
            s = srcs[$urandom % 3];
            n = int'($urandom % STAGES);
            cfg(s, n);
            @(posedge clk_out);
            measure(per);
            check(per == exp_per(s, n), "R6", "source period", per, exp_per(s, n));
        end

        // R5: disable during a high phase
        cfg(2'b00, 3);
        @(posedge clk_out);
        @(posedge clk_out);
        mon_half = exp_per(2'b00, 3) / 2;
        mon_on = 1;
        #20;
        @(negedge clk);
        en = 0;
        repeat (int'(exp_per(2'b00, 3) / 8) + 4) @(negedge clk);
        check(clk_out == 0, "R5", "low after stop", clk_out, 0);
        e0 = edges;
        repeat (200) @(negedge clk);
        check(edges == e0, "R5", "stays low", edges - e0, 0);

        // R4: restart from held state
        @(negedge clk);
        en = 1;
        @(posedge clk_out);
        measure(per);
        check(per == exp_per(2'b00, 3), "R4", "period after restart", per, exp_per(2'b00, 3));

        // R5: disable during a low phase
        @(negedge clk_out);
        #8;
        @(negedge clk);
        en = 0;
        repeat (int'(exp_per(2'b00, 3) / 8) + 4) @(negedge clk);
        check(clk_out == 0, "R5", "low after stop in low", clk_out, 0);
        quiet("R5", 150);
        @(negedge clk);
        en = 1;
        @(posedge clk_out);
        measure(per);
        check(per == exp_per(2'b00, 3), "R4", "second restart", per, exp_per(2'b00, 3));
        @(posedge clk_out);
        mon_on = 0;

        // R9: bypass
        @(negedge clk);
        byp = 1;
        measure(per);
        check(per == 8, "R9", "bypass xtal", per, 8);
        cfg(2'b10, 3);
        measure(per);
        check(per == 16, "R9", "bypass bus", per, 16);

        // R8: gate off, even in bypass
        @(negedge clk);
        gate = 0;
        quiet("R8", 300);
        @(negedge clk);
        byp = 0;
        cfg(2'b00, 0);
        quiet("R8", 300);
        @(negedge clk);
        gate = 1;

        // R7: reserved source code
        cfg(2'b01, 0);
        quiet("R7", 600);
        cfg(2'b00, 2);
        @(posedge clk_out);
        measure(per);
        check(per == exp_per(2'b00, 2), "R7", "recovery", per, exp_per(2'b00, 2));

        // R1: reset while running
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        check(clk_out == 0, "R1", "reset mid-run", clk_out, 0);
        en = 0;
        @(negedge clk);
        rst = 0;
        repeat (40) @(negedge clk);
        check(clk_out == 0, "R1", "idle after reset", clk_out, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule